// File: doc/BRIEF.md
# Redial and Save Digit Memory Controller

This block sits between the keypad decoder and the dial sequencer of a telephone dialer. It watches validated key codes and the hook state, keeps the number dialed in the current call in a redial store, and on request duplicates that number into a separate save store. When the combined redial/pause key or the save key is the first key of a call, the block replays the matching store to the dial sequencer one digit at a time over a ready/valid handshake.

Digits typed by hand come out as a one-cycle event, together with the pause that the redial/pause key produces when it is not the first key of the call. The downstream sequencer turns these events into tones or pulses. A replayed number counts as the start of the current call, so digits typed afterwards are appended to it. Flash keys are never recorded. A flash starts a fresh dialing sequence, so the following key is treated as a first key again.

Top module: `redial_save_ctrl`

## Requirements
- R1: After reset both stores are empty, `live_stb` and `rp_valid` are low, and a redial or save key pressed first produces neither a live event nor a replay.
- R2: Key codes 0 to 11 are digits: 0 to 9 are the numerals, 10 is star and pulse-to-tone, and 11 is hash. A digit key accepted at a clock edge raises `live_stb` with `live_code` equal to the key for exactly the following cycle. The first digit of a call restarts the redial store at position 0.
- R3: The redial/pause key (code 12) pressed as the first key of a call, with 1 to 32 digits stored, replays the stored digits in dialing order. `rp_valid` rises in the cycle after the key. Each digit is taken on a cycle with `rp_valid` and `rp_ready` both high. While `rp_ready` is low, `rp_valid` and `rp_digit` hold.
- R4: The redial/pause key pressed at any later point gives a live event with code 12, which is the pause, and stores code 12 as a digit.
- R5: Once more than 32 digits have been dialed in a call, redial is inhibited: the redial/pause key pressed first in a later call produces no replay.
- R6: The save key (code 13) pressed after at least one digit of the current call copies the redial store and its length into the save store. It produces no live event.
- R7: The save key pressed as the first key of a call replays the save store, and the replayed number becomes the redial number. If the save store is empty, nothing happens.
- R8: Digits typed after a replay are appended to the replayed number, and a later redial replays the whole sequence.
- R9: A flash key (code 14) produces no live event and is never stored. It makes the next key a first key again and makes the next digit restart the redial store.
- R10: While on-hook (`off_hook` low), keys are ignored and any replay stops by the next cycle. A call in which no digit is dialed leaves the redial store unchanged.
- R11: Keys arriving while a replay is in progress are ignored and are not stored.
- R12: Code 15 is not a key. It is ignored and does not use up the first-key position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| off_hook | input | 1 | 1 while the handset is off-hook |
| key_valid | input | 1 | Strobe marking a validated key |
| key_code | input | 4 | Key code (digits 0-11, 12 redial/pause, 13 save, 14 flash, 15 none) |
| live_stb | output | 1 | One-cycle event for a typed digit or pause |
| live_code | output | 4 | Code of the live event (12 = pause) |
| rp_valid | output | 1 | Replay digit available |
| rp_digit | output | 4 | Replay digit code |
| rp_ready | input | 1 | Downstream accepts the replay digit |

## Verification
The hardest state to reach is the edge between 32 and 33 digits in one call, where the meaning of a later redial key changes. A second hard case is a replay held by downstream back-pressure while keys keep arriving. The stimulus sweeps every call length from 1 to 33, redials each one under an irregular ready pattern, and checks every digit and its hold across stalls. Directed calls then combine pauses, save, flash, hook drops and stray keys during replay. Each of these calls is followed by a redial, which shows that the store was or was not changed.

// File: rtl/rsd_pkg.sv
// Shared codes and key classification type for the redial/save controller.
package rsd_pkg;
    typedef logic [3:0] code_t;

    localparam code_t K_HASH  = 4'd11;  // highest plain digit code
    localparam code_t K_RP    = 4'd12;  // redial/pause key, also the stored pause
    localparam code_t K_SAVE  = 4'd13;
    localparam code_t K_FLASH = 4'd14;
    localparam code_t D_PAUSE = 4'd12;

    typedef struct packed {
        logic digit;
        logic rp;
        logic save;
        logic flash;
    } key_cls_t;
endpackage

// File: rtl/rsd_keydec.sv
// Classifies a qualified key code into digit / redial-pause / save / flash.
// Assumes: key_en already folds in hook state and replay-busy blocking.
module rsd_keydec
    import rsd_pkg::*;
(
    input  logic     key_en,
    input  code_t    code,
    output key_cls_t cls
);
    // Decode one key; code 15 matches nothing.
    always_comb begin
        cls.digit = key_en && (code <= K_HASH);
        cls.rp    = key_en && (code == K_RP);
        cls.save  = key_en && (code == K_SAVE);
        cls.flash = key_en && (code == K_FLASH);
    end
endmodule

// File: rtl/rsd_store.sv
// Digit store: single-entry write or whole-array parallel load.
// Assumes: wr_en and ld_en are never both asserted; load wins if they are.
module rsd_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     ld_en,
    input  logic [DEPTH-1:0][DW-1:0] ld_data,
    output logic [DEPTH-1:0][DW-1:0] q
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // Update one entry from a bulk load or an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g] <= '0;
            else if (ld_en)
                q[g] <= ld_data[g];
            else if (wr_en && wr_idx == IW'(g))
                q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/rsd_replay.sv
// Replay sequencer: walks indices 0..len-1, advancing on downstream ready.
// Assumes: start only while idle and with len >= 1; abort has priority.
module rsd_replay #(
    parameter int DEPTH = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] len,
    input  logic          abort,
    input  logic          rdy,
    output logic          valid,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] last_q;

    // Track the active replay position and its end point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            idx    <= '0;
            last_q <= '0;
        end else if (abort) begin
            valid <= 1'b0;
        end else if (start && !valid) begin
            valid  <= 1'b1;
            idx    <= '0;
            last_q <= IW'(len - 1'b1);
        end else if (valid && rdy) begin
            if (idx == last_q)
                valid <= 1'b0;
            else
                idx <= idx + 1'b1;
        end
    end

    // R3: a stalled digit stays offered at the same position
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !rdy && !abort |=> valid && $stable(idx));
    // R3: position never runs past the end of the stored number
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> idx <= last_q);
endmodule

// File: rtl/redial_save_ctrl.sv
// Redial and save digit memory controller.
// Records the digits of each call, copies them to a save store on request and
// replays either store when its key is the first key of a call.
// Assumes: key_valid is a one-cycle strobe per validated key.
module redial_save_ctrl
    import rsd_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       off_hook,
    input  logic       key_valid,
    input  logic [3:0] key_code,
    output logic       live_stb,
    output logic [3:0] live_code,
    output logic       rp_valid,
    output logic [3:0] rp_digit,
    input  logic       rp_ready
);
    localparam int IW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 2);

    key_cls_t                cls;
    logic [DEPTH-1:0][3:0]   red_q, save_q;
    logic [LW-1:0]           red_len, save_len, rp_len;
    logic [IW-1:0]           rp_idx, red_wr_idx;
    logic                    first_q, fresh_q;
    logic                    red_ok, store_dig, red_wr, start_redial, start_save, copy_to_save;
    code_t                   dig_val;

    rsd_keydec u_dec (
        .key_en (key_valid && off_hook && !rp_valid),
        .code   (key_code),
        .cls    (cls)
    );

    // Decide what the accepted key does in the current session state.
    always_comb begin
        red_ok       = (red_len != '0) && (red_len <= LW'(DEPTH));
        store_dig    = cls.digit || (cls.rp && !first_q);
        dig_val      = cls.rp ? D_PAUSE : key_code;
        red_wr       = store_dig && (fresh_q || red_len < LW'(DEPTH));
        red_wr_idx   = fresh_q ? '0 : red_len[IW-1:0];
        start_redial = cls.rp && first_q && red_ok;
        start_save   = cls.save && first_q && (save_len != '0);
        copy_to_save = cls.save && !first_q && !fresh_q && red_ok;
        rp_len       = start_save ? save_len : red_len;
    end

    rsd_store #(.DEPTH(DEPTH), .DW(4)) u_red (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (red_wr),
        .wr_idx  (red_wr_idx),
        .wr_data (dig_val),
        .ld_en   (start_save),
        .ld_data (save_q),
        .q       (red_q)
    );

    rsd_store #(.DEPTH(DEPTH), .DW(4)) u_save (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (1'b0),
        .wr_idx  ('0),
        .wr_data ('0),
        .ld_en   (copy_to_save),
        .ld_data (red_q),
        .q       (save_q)
    );

    rsd_replay #(.DEPTH(DEPTH)) u_rep (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_redial || start_save),
        .len   (rp_len),
        .abort (!off_hook),
        .rdy   (rp_ready),
        .valid (rp_valid),
        .idx   (rp_idx)
    );

    assign rp_digit = red_q[rp_idx];

    // Session flags, lengths and the live digit event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q   <= 1'b1;
            fresh_q   <= 1'b1;
            red_len   <= '0;
            save_len  <= '0;
            live_stb  <= 1'b0;
            live_code <= '0;
        end else begin
            live_stb  <= store_dig;
            live_code <= dig_val;
            if (!off_hook || cls.flash) begin
                first_q <= 1'b1;
                fresh_q <= 1'b1;
            end else if (cls.digit || cls.rp || cls.save) begin
                first_q <= 1'b0;
                if (store_dig || start_redial || start_save)
                    fresh_q <= 1'b0;
            end
            if (store_dig) begin
                if (fresh_q)
                    red_len <= LW'(1);
                else if (red_len <= LW'(DEPTH))
                    red_len <= red_len + 1'b1;
            end else if (start_save) begin
                red_len <= save_len;
            end
            if (copy_to_save)
                save_len <= red_len;
        end
    end

    // R11: a live event never coincides with an active replay
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(live_stb && rp_valid));
    // R5: redial length saturates one past the store depth
    p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        red_len <= LW'(DEPTH + 1));
    // R6: save length never exceeds the store depth
    p_save_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        save_len <= LW'(DEPTH));
    // R10: going on-hook ends any replay by the next cycle
    p_hook_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !off_hook |=> !rp_valid);
    // R9: a flash key never yields a live event
    p_flash_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && key_code == K_FLASH |=> !live_stb);
endmodule

// File: tb/redial_save_ctrl_tb.sv
module redial_save_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       off_hook = 1'b0;
    logic       key_valid = 1'b0;
    logic [3:0] key_code = 4'd15;
    logic       rp_ready = 1'b0;
    logic       live_stb, rp_valid;
    logic [3:0] live_code, rp_digit;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int exp_d[64];
    int exp_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    redial_save_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .off_hook(off_hook),
        .key_valid(key_valid), .key_code(key_code),
        .live_stb(live_stb), .live_code(live_code),
        .rp_valid(rp_valid), .rp_digit(rp_digit), .rp_ready(rp_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic press(input logic [3:0] c);
        @(negedge clk);
        key_valid = 1'b1;
        key_code  = c;
        @(negedge clk);
        key_valid = 1'b0;
        key_code  = 4'd15;
    endtask

    // Press a digit or pause key and expect a live event carrying code c.
    task automatic dial(input logic [3:0] c, input string req);
        press(c);
        check(live_stb && live_code == c, req, {live_stb, live_code}, {1'b1, c});
    endtask

    task automatic quiet(input logic [3:0] c, input string req);
        press(c);
        check(!live_stb, req, live_stb, 0);
    endtask

    task automatic set_hook(input bit v);
        @(negedge clk);
        off_hook = v;
        @(negedge clk);
    endtask

    task automatic new_call();
        set_hook(0);
        set_hook(1);
    endtask

    task automatic exp_clear();
        exp_n = 0;
    endtask

    task automatic exp_push(input int d);
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    // Collect a replay under an irregular ready pattern and compare it to exp_d.
    task automatic replay_check(input string req);
        int got = 0;
        int guard = 0;
        bit hv = 0;
        logic [3:0] hd = '0;
        if (exp_n == 0) begin
            int seen = 0;
            for (int k = 0; k < 4; k++) begin
                if (rp_valid) seen++;
                @(negedge clk);
            end
            check(seen == 0, req, seen, 0);
            return;
        end
        while (guard < 400) begin
            guard++;
            if (hv)
                check(rp_valid && rp_digit == hd, req, rp_digit, hd);
            if (!rp_valid) break;
            rp_ready = (guard % 3 != 0);
            hv = 0;
            if (rp_ready) begin
                if (got < 64)
                    check(rp_digit == exp_d[got], req, rp_digit, exp_d[got]);
                got++;
            end else begin
                hv = 1;
                hd = rp_digit;
            end
            @(negedge clk);
        end
        rp_ready = 1'b0;
        check(got == exp_n, req, got, exp_n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(!live_stb && !rp_valid, "R1", {live_stb, rp_valid}, 0);
        set_hook(1);
        // R1/R7: save first with empty save store does nothing
        quiet(4'd13, "R1");
        exp_clear();
        replay_check("R7");
        new_call();
        // R1: redial first with empty redial store does nothing
        quiet(4'd12, "R1");
        replay_check("R1");

        // R2/R3/R5: sweep every call length from 1 to 33
        for (int n = 1; n <= 33; n++) begin
            new_call();
            exp_clear();
            for (int i = 0; i < n; i++) begin
                dial(4'((i * 5 + n) % 12), "R2");
                exp_push((i * 5 + n) % 12);
            end
            new_call();
            press(4'd12);
            if (n > 32) begin
                check(!live_stb, "R5", live_stb, 0);
                exp_clear();
                replay_check("R5");
            end else begin
                replay_check("R3");
            end
        end

        // R4: redial/pause key after digits stores a pause
        new_call();
        exp_clear();
        dial(4'd3, "R2"); exp_push(3);
        dial(4'd1, "R2"); exp_push(1);
        dial(4'd12, "R4"); exp_push(12);
        dial(4'd10, "R2"); exp_push(10);
        new_call();
        press(4'd12);
        replay_check("R4");

        // R6/R7/R8: save, overwrite redial, replay save, then cascade
        new_call();
        exp_clear();
        dial(4'd7, "R2"); exp_push(7);
        dial(4'd0, "R2"); exp_push(0);
        dial(4'd11, "R2"); exp_push(11);
        dial(4'd9, "R2"); exp_push(9);
        quiet(4'd13, "R6");
        new_call();
        dial(4'd2, "R2");
        dial(4'd2, "R2");
        new_call();
        press(4'd13);
        replay_check("R7");
        dial(4'd4, "R8"); exp_push(4);
        dial(4'd5, "R8"); exp_push(5);
        new_call();
        press(4'd12);
        replay_check("R8");

        // R9: flash is silent, not stored, and re-arms redial
        new_call();
        exp_clear();
        dial(4'd6, "R2"); exp_push(6);
        dial(4'd8, "R2"); exp_push(8);
        quiet(4'd14, "R9");
        press(4'd12);
        check(!live_stb, "R9", live_stb, 0);
        replay_check("R9");

        // R10: an empty call leaves the store intact
        new_call();
        new_call();
        press(4'd12);
        replay_check("R10");

        // R11: keys during a stalled replay are ignored
        new_call();
        press(4'd12);
        quiet(4'd5, "R11");
        check(rp_valid && rp_digit == 4'd6, "R11", rp_digit, 6);
        replay_check("R11");
        new_call();
        press(4'd12);
        replay_check("R11");

        // R10: going on-hook aborts a replay
        new_call();
        press(4'd12);
        check(rp_valid, "R10", rp_valid, 1);
        set_hook(0);
        check(!rp_valid, "R10", rp_valid, 0);
        // R10: keys while on-hook are ignored
        quiet(4'd3, "R10");

        // R12: code 15 is ignored and keeps the first-key position
        set_hook(1);
        quiet(4'd15, "R12");
        press(4'd12);
        replay_check("R12");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule